// File: doc/BRIEF.md
# Pulse Input Qualifying Filter

This block cleans up one asynchronous pulse input before it feeds an event counter. The raw input first passes through a short synchronizer. After that, the filter takes exactly one sample on each rising edge of its clock. In a system this clock is the divided tick from a prescaler. The filtered level changes state only after the synchronized input has held the opposite value for a programmable run of consecutive samples. The run length is a power of two, 2^N samples, where N comes from a 4-bit select.

Every rising edge of the filtered level produces a one-cycle count strobe for the downstream counter. A bypass mode skips the qualification: the filtered level then follows the synchronized input directly, so each assertion of the input gives one strobe.

While the block is disabled, the synchronizer and the filtered level are both forced to the asserted state. An input that is already high when the block is enabled therefore causes no count.

Top module: `pulse_glitch_filter`

## Requirements
- R1: In reset, `filt_level` is 1 and `count_pulse` is 0.
- R2: While `en` is 0, `filt_level` stays 1 and `count_pulse` stays 0, whatever `din` does. If `din` is high when `en` rises, no strobe follows.
- R3: `din` crosses a two-register synchronizer, and the filter sees each value on the third rising edge after it is applied. While disabled, the synchronizer stages are held at 1.
- R4: In filter mode (`en`=1, `bypass`=0), `filt_level` rises on the edge that takes the 2^N-th consecutive high sample. N equals `sel` for values 1 to 15, and `sel`=0 acts as N=1. With `din` raised just after edge c, the new level appears after edge c+2^N+2.
- R5: A sample that matches the current `filt_level` restarts the run. A run shorter than 2^N samples changes nothing.
- R6: Release is qualified in the same way. `filt_level` falls only after 2^N consecutive low samples.
- R7: `count_pulse` is high for exactly one cycle. That cycle is the one in which `filt_level` first shows 1 after a rise that happened while enabled, and there is no other strobe.
- R8: In bypass mode (`en`=1, `bypass`=1), `filt_level` takes the synchronized sample on every edge, three edges after `din`. Each high pulse of `din`, even a single cycle long, yields one strobe.
- R9: A square wave with half-period 2^N samples is counted on every period, giving the top rate of one strobe per 2^(N+1) edges. A half-period of 2^N-1 samples yields no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock (prescaler tick domain) |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low forces the asserted idle state |
| bypass | input | 1 | 1 skips qualification |
| sel | input | SEL_W | Run-length exponent N (0 treated as 1) |
| din | input | 1 | Raw asynchronous pulse input |
| filt_level | output | 1 | Qualified input level |
| count_pulse | output | 1 | One-cycle strobe per rising edge of `filt_level` |

## Verification
The hardest case to reach is the largest run length, where `filt_level` must not move until sample 32768 of an unbroken run. The bench sets N=15, holds `din` high for that whole stretch, and checks the level both one edge before and on the exact edge the requirement predicts. It then reaches the counting-rate limit with square waves at exactly 2^(N+1) and one sample short per half period. Each square wave starts from a settled low level, so the expected strobe cycles follow directly from R4.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

  typedef enum logic [1:0] {
    PGF_OFF    = 2'd0,
    PGF_BYPASS = 2'd1,
    PGF_FILTER = 2'd2
  } pgf_mode_e;

  function automatic pgf_mode_e pgf_mode(input logic en, input logic byp);
    if (!en)     return PGF_OFF;
    else if (byp) return PGF_BYPASS;
    else         return PGF_FILTER;
  endfunction

endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst || hold) chain_q[i] <= 1'b1;
        else if (i == 0) chain_q[i] <= d;
        else             chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pgf_qualifier.sv
module pgf_qualifier
  import pgf_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pgf_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             samp,
  output logic             lvl_q,
  output logic             lvl_d
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] run_q, run_d;
  logic [SEL_W-1:0] n_eff;
  logic [CNT_W-1:0] limit;
  logic             differs, reached;

  always_comb begin
    n_eff   = (sel == '0) ? SEL_W'(1) : sel;
    limit   = (ONE << n_eff) - ONE;
    differs = samp ^ lvl_q;
    reached = (run_q >= limit);
    unique case (mode)
      PGF_OFF: begin
        lvl_d = 1'b1;
        run_d = '0;
      end
      PGF_BYPASS: begin
        lvl_d = samp;
        run_d = '0;
      end
      default: begin
        lvl_d = (differs && reached) ? samp : lvl_q;
        run_d = (!differs || reached) ? '0 : run_q + ONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/pgf_strobe.sv
module pgf_strobe (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic lvl_cur,
  input  logic lvl_next,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= active & lvl_next & ~lvl_cur;
  end
endmodule

// File: rtl/pulse_glitch_filter.sv
module pulse_glitch_filter
  import pgf_pkg::*;
#(
  parameter int SEL_W       = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             bypass,
  input  logic [SEL_W-1:0] sel,
  input  logic             din,
  output logic             filt_level,
  output logic             count_pulse
);
  pgf_mode_e mode;
  logic      samp_w;
  logic      lvl_q, lvl_d;

  assign mode = pgf_mode(en, bypass);

  pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .hold (mode == PGF_OFF),
    .d    (din),
    .q    (samp_w)
  );

  pgf_qualifier #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .sel   (sel),
    .samp  (samp_w),
    .lvl_q (lvl_q),
    .lvl_d (lvl_d)
  );

  pgf_strobe u_strobe (
    .clk      (clk),
    .rst      (rst),
    .active   (mode != PGF_OFF),
    .lvl_cur  (lvl_q),
    .lvl_next (lvl_d),
    .pulse    (count_pulse)
  );

  assign filt_level = lvl_q;
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
  parameter int SEL_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             bypass,
  input logic [SEL_W-1:0] sel,
  input logic             samp,
  input logic             filt_level,
  input logic             count_pulse
);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W:0]   seen_q;
  logic [CNT_W:0]   need;
  logic [SEL_W-1:0] n_eff;

  always_comb begin
    n_eff = (sel == '0) ? SEL_W'(1) : sel;
    need  = (ONE << n_eff) - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || bypass || (samp == filt_level)) seen_q <= '0;
    else if (seen_q != '1)                            seen_q <= seen_q + ONE;
  end

  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    ($rose(filt_level) && $past(en)) |-> count_pulse);                         // R7

  AST_STROBE_NEEDS_RISE: assert property (@(posedge clk) disable iff (rst)
    count_pulse |-> (filt_level && !$past(filt_level)));                       // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    count_pulse |=> !count_pulse);                                             // R7

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (filt_level && !count_pulse));                              // R2

  AST_RUN_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(bypass) && (filt_level != $past(filt_level)))
      |-> ($past(seen_q) >= $past(need)));                                     // R4

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && $past(bypass)) |-> (filt_level == $past(samp)));             // R8
endmodule

bind pulse_glitch_filter pgf_checker #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .bypass      (bypass),
  .sel         (sel),
  .samp        (samp_w),
  .filt_level  (filt_level),
  .count_pulse (count_pulse)
);

// File: tb/tb_pulse_glitch_filter.sv
`timescale 1ns/1ps
module tb_pulse_glitch_filter;
  logic       clk = 1'b0;
  logic       rst, en, bypass, din;
  logic [3:0] sel;
  logic       filt_level, count_pulse;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_glitch_filter dut (
    .clk(clk), .rst(rst), .en(en), .bypass(bypass), .sel(sel),
    .din(din), .filt_level(filt_level), .count_pulse(count_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic level_is(input bit v, input string req);
    check(filt_level == v, req, filt_level, v);
  endtask

  task automatic push(input int c, input string req);
    exp_q.push_back(c);
    tag_q.push_back(req);
  endtask

  // drive din to v; level must change exactly on edge c+T+2
  task automatic qualify(input bit v, input int t, input string req);
    int c;
    c = cyc;
    din = v;
    if (v) push(c + t + 2, req);
    step(t + 1);
    level_is(!v, req);
    step(1);
    level_is(v, req);
  endtask

  // scoreboard monitor: every strobe must match the next expected cycle (R7)
  always @(negedge clk) begin
    if (!rst && count_pulse) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R7: unexpected strobe actual=cycle %0d expected=none", cyc);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != cyc) begin
          n_fail++;
          $display("FAIL %s: strobe actual=cycle %0d expected=cycle %0d", t, cyc, e);
        end
      end
    end
  end

  initial begin
    #900000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; en = 0; bypass = 0; din = 0; sel = 4'd1;
    step(4);
    check(filt_level == 1 && count_pulse == 0, "R1", {filt_level, count_pulse}, 2);
    rst = 0;

    // R2: input activity while disabled has no effect
    for (int i = 0; i < 6; i++) begin
      din = ~din;
      step(1);
      level_is(1'b1, "R2");
    end

    // R2: enable with input already high -> no count
    din = 1; step(1);
    en = 1;
    step(10);
    level_is(1'b1, "R2");

    // R6 + R3 latency: release qualified, N=1
    qualify(1'b0, 2, "R6");

    // R5: short high run with N=2 is discarded
    sel = 4'd2;
    din = 1; step(3);
    din = 0; step(4);
    level_is(1'b0, "R5");
    qualify(1'b1, 4, "R4");

    // R5/R6: short low run on release is discarded
    din = 0; step(3);
    din = 1; step(4);
    level_is(1'b1, "R5");
    qualify(1'b0, 4, "R6");

    // R4: sel=0 acts as N=1
    sel = 4'd0;
    qualify(1'b1, 2, "R4");
    qualify(1'b0, 2, "R6");

    // R4: largest run length, N=15
    sel = 4'd15;
    qualify(1'b1, 32768, "R4");
    sel = 4'd1;
    qualify(1'b0, 2, "R6");

    // R9: square wave at the top rate, N=1 (half-period 2)
    for (int i = 0; i < 4; i++) begin
      push(cyc + 4, "R9");
      din = 1; step(2);
      din = 0; step(2);
    end
    step(8);
    level_is(1'b0, "R9");

    // R9: half-period one short -> no strobe
    for (int i = 0; i < 8; i++) begin
      din = ~din;
      step(1);
    end
    din = 0; step(6);
    level_is(1'b0, "R9");

    // R8: bypass, single-cycle pulses each counted
    bypass = 1;
    step(2);
    for (int i = 0; i < 3; i++) begin
      push(cyc + 3, "R8");
      din = 1; step(1);
      din = 0; step(1);
    end
    step(3);
    level_is(1'b0, "R8");

    // R3: bypass path latency is three edges
    begin
      int c0;
      c0 = cyc;
      push(c0 + 3, "R3");
      din = 1; step(2);
      level_is(1'b0, "R3");
      step(1);
      level_is(1'b1, "R3");
      din = 0; step(4);
      level_is(1'b0, "R8");
    end

    // R2: disable/re-enable with input high in bypass -> no count
    din = 1; step(2);
    en = 0; step(3);
    level_is(1'b1, "R2");
    en = 1; step(6);
    level_is(1'b1, "R2");

    step(5);
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule